// File: doc/BRIEF.md
# Startup and Fault Protection Sequencer

This block is the control state machine of a flyback converter's primary-side start-up controller. Single-bit comparator results arrive already digitised: line undervoltage, line overvoltage, auxiliary-winding overvoltage and overcurrent. The block also receives a level saying that the secondary controller has taken over regulation, and it receives the secondary's gate request.

From these inputs it decides when the power switch may be driven. While the secondary is not yet in control, the block generates its own soft-start PWM from a free-running period counter. The pulse width starts at a small minimum and grows steadily up to an open-loop on-time ceiling. Once the secondary reports control, the gate follows the secondary's request, subject to a longer closed-loop on-time ceiling.

Each fault class has its own recovery:
- Line undervoltage holds the gate off and restarts with soft-start as soon as the line returns.
- Line overvoltage, auxiliary overvoltage and open-loop overcurrent hold the gate off for as long as the fault lasts. A fixed restart delay follows, then a fresh soft-start.
- Closed-loop overcurrent only ends the present pulse.
- A halt request latches everything off until reset.

All durations are parameters counted in system-clock cycles.

Top module: `startup_fault_seq`

## Requirements
- R1: After reset the block is in the line-wait phase (phase_o=0) with gate_o and gate_en low. It leaves that phase for soft-start (phase_o=1) only once line_uv and line_ov are both low.
- R2: In soft-start (phase_o=1) the gate pulses with a period of PERIOD_CYC cycles. The first pulse lasts MIN_ON_CYC cycles. The pulse width grows by one cycle every SS_STEP_CYC cycles, is fixed at the start of each period, and never exceeds OL_MAX_ON_CYC cycles.
- R3: With sec_ctrl high in soft-start the block enters closed loop (phase_o=2). There gate_o follows sec_gate one clock later, and one request yields at most CL_MAX_ON_CYC high cycles.
- R4: line_uv forces the gate low on the next clock and moves a running block to the hold phase (phase_o=3). When only undervoltage was involved, its clearing leads straight to soft-start.
- R5: line_ov moves the block to hold (phase_o=3) while it lasts. Its clearing leads to the restart-wait phase (phase_o=4), never directly to soft-start.
- R6: The restart-wait phase lasts exactly RESTART_CYC cycles and then enters soft-start. Loss of sec_ctrl in closed loop enters restart-wait.
- R7: aux_ov moves the block from soft-start to hold and then to restart-wait. It is ignored in closed loop. It is also ignored for AUX_BLANK_CYC cycles starting with the cycle in which gate_o falls.
- R8: ocp is ignored for the first LEB_CYC cycles of a gate pulse. A qualified ocp in closed loop ends that pulse only: the phase stays 2 and the next sec_gate request is served in full. A qualified ocp in soft-start leads to hold and then restart-wait.
- R9: halt_req moves the block to the latched-off phase (phase_o=5) with gate_o low. Only reset leaves that phase.
- R10: Among simultaneous conditions, halt_req wins over line and auxiliary faults, and these win over pulse-by-pulse overcurrent. For example, ocp together with line_uv in closed loop gives hold, not a cut pulse.
- R11: gate_o is never high while gate_en is low. gate_en is high only in soft-start and closed loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_uv | input | 1 | Line below undervoltage threshold |
| line_ov | input | 1 | Line above overvoltage threshold |
| aux_ov | input | 1 | Auxiliary winding above overvoltage threshold |
| ocp | input | 1 | Switch current above limit |
| sec_ctrl | input | 1 | Secondary controller regulating |
| sec_gate | input | 1 | Gate request from secondary |
| halt_req | input | 1 | Request to latch off |
| gate_o | output | 1 | Power switch gate command |
| gate_en | output | 1 | Gate driving permitted in this phase |
| phase_o | output | 3 | Current phase (0 wait, 1 soft-start, 2 closed loop, 3 hold, 4 restart-wait, 5 latched) |

## Verification
The bench goes after the hold-exit destination. A design that lost the restart flag would return to soft-start straight after an overvoltage, and one that set it for undervoltage would add a needless restart delay. Blanking windows are probed at their exact edges. An overvoltage pulse confined to the post-fall window must leave soft-start running, and a closed-loop overcurrent must yield exactly LEB_CYC+1 gate cycles; an off-by-one in either counter shifts these counts. The restart delay is counted to the cycle. The open-loop pulse widths are measured against the ramp, the closed-loop cap is measured against a long request, and the latch is shown to survive every input being cleared.

// File: rtl/ssq_pkg.sv
// Package: shared phase encoding for the start-up sequencer.
// Assumes: phase values are visible on the top-level phase_o port.
package ssq_pkg;
    typedef enum logic [2:0] {
        PH_WAIT    = 3'd0,
        PH_SOFT    = 3'd1,
        PH_CLOSED  = 3'd2,
        PH_HOLD    = 3'd3,
        PH_RESTART = 3'd4,
        PH_LATCH   = 3'd5
    } phase_e;
endpackage

// File: rtl/ssq_pwm.sv
// Open-loop soft-start PWM. A period counter runs while en is high.
// The pulse width ramps from MIN_ON to MAX_ON, one cycle per SS_STEP cycles.
// The width is captured at each period start so a pulse never changes shape mid-way.
// Assumes: MIN_ON <= MAX_ON < PERIOD, SS_STEP >= 1; deasserting en restarts the ramp.
module ssq_pwm #(
    parameter int PERIOD  = 833,
    parameter int MIN_ON  = 25,
    parameter int MAX_ON  = 475,
    parameter int SS_STEP = 555
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pwm_on
);
    localparam int PW = $clog2(PERIOD + 1);
    localparam int SW = $clog2(SS_STEP + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] W_MIN  = PW'(MIN_ON);
    localparam logic [PW-1:0] W_MAX  = PW'(MAX_ON);
    localparam logic [SW-1:0] S_LAST = SW'(SS_STEP - 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] ramp;
    logic [PW-1:0] cur_w;
    logic [PW-1:0] w_eff;
    logic [SW-1:0] step;

    // Width in force: the ramp value at period start, otherwise the captured width.
    always_comb begin
        w_eff  = (cnt == '0) ? ramp : cur_w;
        pwm_on = en && (cnt < w_eff);
    end

    // Period counter, width capture and ramp stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            ramp  <= W_MIN;
            cur_w <= W_MIN;
            step  <= '0;
        end else begin
            cnt   <= (cnt == P_LAST) ? '0 : cnt + 1'b1;
            cur_w <= w_eff;
            if (step == S_LAST) begin
                step <= '0;
                if (ramp < W_MAX) ramp <= ramp + 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // R2: the ramp never falls while soft-start continues.
    p_ramp_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (ramp >= $past(ramp)));

    // R2: no pulse extends beyond the open-loop ceiling.
    p_width_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_on |-> (cnt < W_MAX));
endmodule

// File: rtl/ssq_blank.sv
// Edge blanker for a comparator flag. Passes raw through only once BLANK_CYC
// cycles have elapsed since the chosen edge of gate.
// RISE=1: the window follows a rising edge, and the flag is qualified only while gate is high.
// RISE=0: the window follows a falling edge.
// Assumes: BLANK_CYC >= 1; the edge cycle itself is blanked.
module ssq_blank #(
    parameter int BLANK_CYC = 5,
    parameter bit RISE      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic raw,
    output logic qual
);
    localparam int AW = $clog2(BLANK_CYC + 1);
    localparam logic [AW-1:0] A_SAT = AW'(BLANK_CYC);

    logic          gate_d;
    logic [AW-1:0] age;
    logic          edge_hit;
    logic          active;

    // Choose which gate edge opens the window and when the flag matters.
    generate
        if (RISE) begin : g_rise
            assign edge_hit = gate & ~gate_d;
            assign active   = gate;
        end else begin : g_fall
            assign edge_hit = ~gate & gate_d;
            assign active   = 1'b1;
        end
    endgenerate

    // Qualified flag: outside the blanking window only.
    always_comb begin
        qual = raw && active && !edge_hit && (age >= A_SAT);
    end

    // Track the previous gate level and the cycles elapsed since the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_d <= 1'b0;
            age    <= A_SAT;
        end else begin
            gate_d <= gate;
            if (edge_hit)          age <= AW'(1);
            else if (age < A_SAT)  age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/ssq_timer.sv
// Restart delay timer. It counts while run is high and raises done in its
// last cycle, so a phase that exits on done lasts exactly TAR_CYC cycles.
// Assumes: TAR_CYC >= 2; dropping run clears the count.
module ssq_timer #(
    parameter int TAR_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(TAR_CYC);
    localparam logic [CW-1:0] C_LAST = CW'(TAR_CYC - 1);

    logic [CW-1:0] cnt;

    // Terminal count flag.
    always_comb done = run && (cnt == C_LAST);

    // Count up while running; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/startup_fault_seq.sv
// Start-up and fault protection sequencer for a flyback primary side.
// It sequences line wait, soft-start, closed loop, fault hold, restart wait and latch-off.
// It also produces the registered gate command.
// Assumes: all inputs are synchronous to clk; durations are in clock cycles;
// OL_MAX_ON_CYC <= CL_MAX_ON_CYC.
module startup_fault_seq
    import ssq_pkg::*;
#(
    parameter int PERIOD_CYC    = 833,
    parameter int MIN_ON_CYC    = 25,
    parameter int OL_MAX_ON_CYC = 475,
    parameter int CL_MAX_ON_CYC = 625,
    parameter int SS_STEP_CYC   = 555,
    parameter int RESTART_CYC   = 50_000_000,
    parameter int LEB_CYC       = 5,
    parameter int AUX_BLANK_CYC = 28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_uv,
    input  logic       line_ov,
    input  logic       aux_ov,
    input  logic       ocp,
    input  logic       sec_ctrl,
    input  logic       sec_gate,
    input  logic       halt_req,
    output logic       gate_o,
    output logic       gate_en,
    output logic [2:0] phase_o
);
    localparam int CLW = $clog2(CL_MAX_ON_CYC + 1);
    localparam logic [CLW-1:0] CL_CAP = CLW'(CL_MAX_ON_CYC);
    localparam int HW = $clog2(CL_MAX_ON_CYC + OL_MAX_ON_CYC + 2);
    localparam logic [HW-1:0] HR_OL = HW'(OL_MAX_ON_CYC);
    localparam logic [HW-1:0] HR_CL = HW'(CL_MAX_ON_CYC);

    phase_e         state, nxt;
    logic           restart_flag, flag_nxt;
    logic           gate_q, gate_nxt;
    logic [CLW-1:0] cl_cnt;
    logic           cl_ok;
    logic           ocp_cut;
    logic           pwm_on;
    logic           ocp_q;
    logic           aux_q;
    logic           tmr_done;
    logic [HW-1:0]  hi_run;

    ssq_pwm #(
        .PERIOD (PERIOD_CYC),
        .MIN_ON (MIN_ON_CYC),
        .MAX_ON (OL_MAX_ON_CYC),
        .SS_STEP(SS_STEP_CYC)
    ) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == PH_SOFT),
        .pwm_on(pwm_on)
    );

    ssq_blank #(.BLANK_CYC(LEB_CYC), .RISE(1'b1)) u_ocp_blank (
        .clk  (clk),
        .rst_n(rst_n),
        .gate (gate_q),
        .raw  (ocp),
        .qual (ocp_q)
    );

    ssq_blank #(.BLANK_CYC(AUX_BLANK_CYC), .RISE(1'b0)) u_aux_blank (
        .clk  (clk),
        .rst_n(rst_n),
        .gate (gate_q),
        .raw  (aux_ov),
        .qual (aux_q)
    );

    ssq_timer #(.TAR_CYC(RESTART_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == PH_RESTART),
        .done (tmr_done)
    );

    // Phase transitions with per-fault recovery and halt as top priority.
    always_comb begin
        nxt      = state;
        flag_nxt = restart_flag;
        case (state)
            PH_WAIT: begin
                if (line_ov) begin
                    nxt      = PH_HOLD;
                    flag_nxt = 1'b1;
                end else if (!line_uv) begin
                    nxt = PH_SOFT;
                end
            end
            PH_SOFT: begin
                if (line_uv || line_ov || aux_q || ocp_q) begin
                    nxt      = PH_HOLD;
                    flag_nxt = line_ov || aux_q || ocp_q;
                end else if (sec_ctrl) begin
                    nxt = PH_CLOSED;
                end
            end
            PH_CLOSED: begin
                if (line_uv || line_ov) begin
                    nxt      = PH_HOLD;
                    flag_nxt = line_ov;
                end else if (!sec_ctrl) begin
                    nxt = PH_RESTART;
                end
            end
            PH_HOLD: begin
                flag_nxt = restart_flag || line_ov;
                if (!(line_uv || line_ov || aux_ov || ocp))
                    nxt = flag_nxt ? PH_RESTART : PH_SOFT;
            end
            PH_RESTART: begin
                if (line_uv || line_ov) begin
                    nxt      = PH_HOLD;
                    flag_nxt = 1'b1;
                end else if (tmr_done) begin
                    nxt = PH_SOFT;
                end
            end
            PH_LATCH: nxt = PH_LATCH;
            default:  nxt = PH_WAIT;
        endcase
        if (halt_req) nxt = PH_LATCH;
    end

    // Gate request for the next cycle: open-loop PWM or capped secondary request.
    always_comb begin
        cl_ok    = cl_cnt < CL_CAP;
        gate_nxt = ((state == PH_SOFT) && (nxt == PH_SOFT) && pwm_on && !ocp_q) ||
                   ((state == PH_CLOSED) && (nxt == PH_CLOSED) && sec_gate &&
                    cl_ok && !ocp_cut && !ocp_q);
    end

    // Phase, restart flag and gate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= PH_WAIT;
            restart_flag <= 1'b0;
            gate_q       <= 1'b0;
        end else begin
            state        <= nxt;
            restart_flag <= (nxt == PH_HOLD) ? flag_nxt : 1'b0;
            gate_q       <= gate_nxt;
        end
    end

    // Closed-loop on-time counter and pulse-cut memory, cleared between requests.
    always_ff @(posedge clk) begin
        if (!rst_n || !sec_gate || state != PH_CLOSED) begin
            cl_cnt  <= '0;
            ocp_cut <= 1'b0;
        end else begin
            if (cl_ok) cl_cnt <= cl_cnt + 1'b1;
            if (ocp_q) ocp_cut <= 1'b1;
        end
    end

    // Run-length of the current gate pulse, used by the on-time checks.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_q) hi_run <= '0;
        else if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end

    assign gate_o  = gate_q;
    assign gate_en = (state == PH_SOFT) || (state == PH_CLOSED);
    assign phase_o = state;

    // R11: the gate is only driven in a driving phase.
    p_gate_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> gate_en);

    // R2: open-loop pulses stay under the open-loop ceiling.
    p_ol_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && state == PH_SOFT) |-> (hi_run < HR_OL));

    // R3: closed-loop pulses stay under the closed-loop ceiling.
    p_cl_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (hi_run < HR_CL));

    // R4: undervoltage drops the gate by the next clock.
    p_uv_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_uv |=> !gate_q);

    // R6: restart-wait leaves for soft-start only on the timer's terminal count.
    p_restart_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RESTART && nxt == PH_SOFT) |-> tmr_done);

    // R7: closed loop is not disturbed by auxiliary overvoltage.
    p_aux_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CLOSED && sec_ctrl && !line_uv && !line_ov && !halt_req)
        |=> (state == PH_CLOSED));

    // R9: a halt request always latches.
    p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (state == PH_LATCH));

    // R9: the latched phase is never left without reset.
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LATCH) |=> (state == PH_LATCH));
endmodule

// File: tb/sim_startup_fault_seq.sv
module sim_startup_fault_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_uv = 1'b1, line_ov = 1'b0, aux_ov = 1'b0, ocp = 1'b0;
    logic       sec_ctrl = 1'b0, sec_gate = 1'b0, halt_req = 1'b0;
    logic       gate_o, gate_en;
    logic [2:0] phase_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int en_viol = 0;
    bit done = 1'b0;

    startup_fault_seq #(
        .PERIOD_CYC(20), .MIN_ON_CYC(2), .OL_MAX_ON_CYC(14), .CL_MAX_ON_CYC(18),
        .SS_STEP_CYC(10), .RESTART_CYC(50), .LEB_CYC(3), .AUX_BLANK_CYC(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_uv(line_uv), .line_ov(line_ov),
        .aux_ov(aux_ov), .ocp(ocp), .sec_ctrl(sec_ctrl), .sec_gate(sec_gate),
        .halt_req(halt_req), .gate_o(gate_o), .gate_en(gate_en), .phase_o(phase_o)
    );

    always #2 clk = ~clk;

    // Vector: uv, ov, aux, ocp, sec_ctrl, halt | cycles | expected phase
    localparam logic [16:0] VEC [0:10] = '{
        {6'b100000, 8'd5,  3'd0},   // R1 line-wait while undervoltage
        {6'b000000, 8'd3,  3'd1},   // R1 soft-start once line good
        {6'b000010, 8'd3,  3'd2},   // R3 hand-over
        {6'b001010, 8'd10, 3'd2},   // R7 aux ignored in closed loop
        {6'b010010, 8'd3,  3'd3},   // R5 overvoltage -> hold
        {6'b000000, 8'd3,  3'd4},   // R5 cleared -> restart wait
        {6'b000000, 8'd60, 3'd1},   // R6 restart -> soft-start
        {6'b100000, 8'd3,  3'd3},   // R4 undervoltage -> hold
        {6'b000000, 8'd3,  3'd1},   // R4 straight back to soft-start
        {6'b110001, 8'd3,  3'd5},   // R10 halt wins
        {6'b000000, 8'd10, 3'd5}    // R9 latch persists
    };

    always @(negedge clk) begin
        cyc++;
        if (gate_o && !gate_en) en_viol++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic next_pulse(output int width, output int rise_cyc);
        int guard = 0;
        width = 0;
        while (gate_o && guard < 1000) begin @(negedge clk); guard++; end
        while (!gate_o && guard < 1000) begin @(negedge clk); guard++; end
        rise_cyc = cyc;
        while (gate_o && guard < 1000) begin width++; @(negedge clk); guard++; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {line_uv, line_ov, aux_ov, ocp, sec_ctrl, sec_gate, halt_req} = 7'b1000000;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int w1, w2, r1, r2, cnt;
        bit prev;
        wait_n(4);
        chk(phase_o == 3'd0 && !gate_o && !gate_en, "R1 reset state", phase_o, 0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            {line_uv, line_ov, aux_ov, ocp, sec_ctrl, halt_req} = VEC[i][16:11];
            wait_n(int'(VEC[i][10:3]) - 1);
            chk(phase_o == VEC[i][2:0], "R1/R3/R4/R5/R6/R7/R9/R10 vector phase",
                phase_o, VEC[i][2:0]);
        end

        // R2 soft-start ramp.
        do_reset();
        chk(phase_o == 3'd0 && !gate_o, "R1 wait under undervoltage", phase_o, 0);
        line_uv = 1'b0;
        next_pulse(w1, r1);
        chk(w1 == 2, "R2 first pulse width", w1, 2);
        next_pulse(w2, r2);
        chk(w2 == 4, "R2 second pulse width", w2, 4);
        chk(r2 - r1 == 20, "R2 period", r2 - r1, 20);
        wait_n(200);
        next_pulse(w1, r1);
        chk(w1 == 14, "R2 saturated width", w1, 14);

        // R3 closed loop with on-time cap and one-cycle latency.
        sec_ctrl = 1'b1;
        wait_n(3);
        chk(phase_o == 3'd2, "R3 closed loop entry", phase_o, 2);
        sec_gate = 1'b1;
        cnt = 0;
        @(negedge clk);
        chk(gate_o == 1'b1, "R3 gate follows request next clock", gate_o, 1);
        if (gate_o) cnt++;
        repeat (29) begin @(negedge clk); if (gate_o) cnt++; end
        sec_gate = 1'b0;
        chk(cnt == 18, "R3 closed-loop on-time cap", cnt, 18);
        wait_n(3);

        // R8 closed-loop overcurrent after blanking cuts one pulse only.
        ocp = 1'b1;
        sec_gate = 1'b1;
        cnt = 0;
        repeat (10) begin @(negedge clk); if (gate_o) cnt++; end
        sec_gate = 1'b0;
        ocp = 1'b0;
        chk(cnt == 4, "R8 pulse cut after blanking window", cnt, 4);
        wait_n(3);
        sec_gate = 1'b1;
        cnt = 0;
        repeat (6) begin @(negedge clk); if (gate_o) cnt++; end
        sec_gate = 1'b0;
        chk(cnt == 6 && phase_o == 3'd2, "R8 next request served in closed loop", cnt, 6);

        // R7 auxiliary overvoltage ignored in closed loop.
        aux_ov = 1'b1;
        wait_n(10);
        aux_ov = 1'b0;
        chk(phase_o == 3'd2, "R7 aux ignored in closed loop", phase_o, 2);

        // R6 restart wait length.
        sec_ctrl = 1'b0;
        @(negedge clk);
        cnt = 0;
        while (phase_o == 3'd4 && cnt < 200) begin cnt++; @(negedge clk); end
        chk(cnt == 50, "R6 restart-wait length", cnt, 50);
        chk(phase_o == 3'd1, "R6 soft-start after wait", phase_o, 1);

        // R7 aux inside post-fall blanking window is ignored.
        prev = gate_o;
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if ((prev && !gate_o) || cnt > 100) break;
            prev = gate_o;
        end
        aux_ov = 1'b1;
        wait_n(4);
        aux_ov = 1'b0;
        wait_n(3);
        chk(phase_o == 3'd1, "R7 aux blanked after gate fall", phase_o, 1);

        // R7 aux in open loop -> hold -> restart wait.
        aux_ov = 1'b1;
        wait_n(12);
        chk(phase_o == 3'd3, "R7 aux open-loop hold", phase_o, 3);
        aux_ov = 1'b0;
        wait_n(2);
        chk(phase_o == 3'd4, "R7 aux then restart wait", phase_o, 4);
        wait_n(55);

        // R8 open-loop overcurrent -> hold -> restart wait.
        chk(phase_o == 3'd1, "R6 soft-start after restart", phase_o, 1);
        ocp = 1'b1;
        wait_n(60);
        chk(phase_o == 3'd3, "R8 open-loop overcurrent hold", phase_o, 3);
        ocp = 1'b0;
        wait_n(2);
        chk(phase_o == 3'd4, "R8 open-loop then restart wait", phase_o, 4);
        wait_n(55);
        sec_ctrl = 1'b1;
        wait_n(3);
        chk(phase_o == 3'd2, "R3 closed loop again", phase_o, 2);

        // R10 line fault beats pulse-by-pulse overcurrent.
        line_uv = 1'b1;
        ocp = 1'b1;
        sec_gate = 1'b1;
        wait_n(2);
        chk(phase_o == 3'd3 && !gate_o, "R10 undervoltage beats overcurrent", phase_o, 3);
        {line_uv, ocp, sec_gate, sec_ctrl} = 4'b0000;
        wait_n(2);
        chk(phase_o == 3'd1, "R4 undervoltage-only hold to soft-start", phase_o, 1);

        // R9 latch and its exit by reset only.
        line_ov = 1'b1;
        halt_req = 1'b1;
        wait_n(2);
        chk(phase_o == 3'd5 && !gate_en, "R9 latch entry", phase_o, 5);
        line_ov = 1'b0;
        halt_req = 1'b0;
        wait_n(20);
        chk(phase_o == 3'd5 && !gate_o, "R9 latch holds", phase_o, 5);
        do_reset();
        chk(phase_o == 3'd0, "R9 reset leaves latch", phase_o, 0);

        chk(en_viol == 0, "R11 gate without enable", en_viol, 0);
        finish_run();
    end
endmodule